// File: doc/BRIEF.md
# Digital Input Conditioner

This block cleans up a single raw digital pin before downstream counters or logic use it. The pin passes through a two-flop synchronizer, an optional polarity inversion and a stable-time filter. The output changes only after the new level has been seen for a required number of consecutive clock samples. The block reports the cleaned level and a one-cycle strobe for each rising or falling change.

The filter has two modes, and each has its own settings table. In debounce mode the index picks a stable time, from none up to 5 ms. In pulse mode the index picks the highest pulse rate that must pass, and the required stable time is half the period of that rate. After reset the output starts at a chosen level. It moves to the pin's level only once the pin has shown that level for the full stable time.

The sample rate is set by the parameter `TICKS_PER_US`, which is clock ticks per microsecond. The default is 80, a 12.5 ns tick. The invert, initial-level, mode and index inputs are static configuration. They are changed while reset is held or while the pin is idle.

Top module: `din_conditioner`

## Requirements
- R1: While `rst_ni` is low, `level_o` equals `init_i`, and `rise_o` and `fall_o` are 0.
- R2: When `invert_i` is 1, the filter acts on the inverted pin, so a steady pin level of 0 shows as `level_o` = 1 and a steady level of 1 shows as 0.
- R3: Let C be the clock edge after which a pin change first meets a required count of N. The new level appears on `level_o` right after edge C+2+N. The two synchronizer flops account for two of those cycles. An index whose stable time is zero is treated as N = 1, so its latency is 3 cycles.
- R4: A pin pulse that lasts fewer than N cycles has no effect on `level_o` and makes no strobe.
- R5: In debounce mode (`mode_i` = 0), N = stable time × `TICKS_PER_US`. The stable times for indices 0 to 8 are 0, 10, 50, 100, 200, 400, 600, 1000 and 5000 µs. Indices 9 to 15 use 5000 µs.
- R6: In pulse mode (`mode_i` = 1), N = floor(500 × `TICKS_PER_US` / rate_kpps), with a minimum of 1. The rates for indices 0 to 7 are 10, 100, 200, 500, 1000, 2000, 4000 and 8000 kpps. Indices 8 to 15 use 8000 kpps.
- R7: `rise_o` is 1 for exactly the cycle in which `level_o` goes from 0 to 1, and `fall_o` is 1 for exactly the cycle in which it goes from 1 to 0. The two strobes are never 1 together, and no strobe occurs without a level change.
- R8: After reset, if the pin (after inversion) differs from `init_i`, `level_o` moves to the pin's level at C+2+N, counted from the release edge, and the matching strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw asynchronous pin |
| mode_i | input | 1 | Filter mode: 0 = debounce, 1 = pulse rate |
| sel_i | input | 4 | Index into the table of the selected mode |
| invert_i | input | 1 | 1 = invert the pin polarity |
| init_i | input | 1 | Output level held during reset |
| level_o | output | 1 | Conditioned level |
| rise_o | output | 1 | One-cycle strobe on a 0-to-1 change |
| fall_o | output | 1 | One-cycle strobe on a 1-to-0 change |

## Verification
The filter is driven with clean steps that hold well past the required count, and the strobe cycle is checked against C+2+N. This separates correct table entries from neighbouring entries and from off-by-one counting. Glitches one cycle shorter than N are then applied, which separates a filter that requires consecutive samples from one that triggers early. Out-of-range indices in both modes show whether the clamping is right. Resets with the pin agreeing and disagreeing with the initial level, with and without inversion, tell the start-up hold apart from a spurious initial transition.

// File: rtl/din_cond_pkg.sv
package din_cond_pkg;

  typedef enum logic {
    FILT_DEBOUNCE = 1'b0,
    FILT_PULSE    = 1'b1
  } filt_mode_e;

  localparam int unsigned SEL_W   = 4;
  localparam int unsigned SEL_N   = 1 << SEL_W;
  localparam int unsigned MAX_US  = 5000;

  // stable time in microseconds per debounce index
  function automatic int unsigned deb_time_us(int unsigned idx);
    case (idx)
      0:       return 0;
      1:       return 10;
      2:       return 50;
      3:       return 100;
      4:       return 200;
      5:       return 400;
      6:       return 600;
      7:       return 1000;
      default: return MAX_US;
    endcase
  endfunction

  // pulse rate limit in kpps per pulse index
  function automatic int unsigned pulse_rate_kpps(int unsigned idx);
    case (idx)
      0:       return 10;
      1:       return 100;
      2:       return 200;
      3:       return 500;
      4:       return 1000;
      5:       return 2000;
      6:       return 4000;
      default: return 8000;
    endcase
  endfunction

  function automatic int unsigned at_least_one(int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int unsigned deb_ticks(int unsigned idx, int unsigned tpu);
    return at_least_one(deb_time_us(idx) * tpu);
  endfunction

  // half period in ticks: (1e6/rate_kpps ns)/2 * tpu/1000
  function automatic int unsigned pulse_ticks(int unsigned idx, int unsigned tpu);
    return at_least_one((500 * tpu) / pulse_rate_kpps(idx));
  endfunction

endpackage

// File: rtl/din_sync.sv
module din_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic s_o,
  output logic vld_o
);

  logic [1:0] meta_q;
  logic [1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      vld_q  <= '0;
    end else begin
      meta_q <= {meta_q[0], pin_i};
      vld_q  <= {vld_q[0], 1'b1};
    end
  end

  assign s_o   = meta_q[1];
  assign vld_o = vld_q[1];

  // R3
  vld_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> vld_o);

endmodule

// File: rtl/din_limit_sel.sv
module din_limit_sel
  import din_cond_pkg::*;
#(
  parameter int unsigned TICKS_PER_US = 80,
  parameter int unsigned CNT_W        = 19
) (
  input  filt_mode_e        mode_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [CNT_W-1:0]  lim_o
);

  logic [CNT_W-1:0] deb_tab [SEL_N];
  logic [CNT_W-1:0] pul_tab [SEL_N];

  for (genvar i = 0; i < SEL_N; i++) begin : g_tab
    localparam int unsigned DEB_T = deb_ticks(i, TICKS_PER_US);
    localparam int unsigned PUL_T = pulse_ticks(i, TICKS_PER_US);
    assign deb_tab[i] = CNT_W'(DEB_T);
    assign pul_tab[i] = CNT_W'(PUL_T);
  end

  always_comb begin
    if (mode_i == FILT_PULSE) lim_o = pul_tab[sel_i];
    else                      lim_o = deb_tab[sel_i];
  end

endmodule

// File: rtl/din_filter.sv
module din_filter #(
  parameter int unsigned CNT_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             vld_i,
  input  logic             s_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             level_o,
  output logic             rise_o,
  output logic             fall_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q, rise_q, fall_q;
  logic             hit;

  assign hit = (cnt_q >= lim_i - CNT_W'(1));

  // init_i is static configuration; reset loads it as the start level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lvl_q  <= init_i;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (!vld_i || s_i == lvl_q) begin
        cnt_q <= '0;
      end else if (hit) begin
        cnt_q  <= '0;
        lvl_q  <= s_i;
        rise_q <= s_i;
        fall_q <= ~s_i;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign level_o = lvl_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;

  // R7
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
  // R7
  rise_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (level_o && !$past(level_o)));
  // R7
  fall_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (!level_o && $past(level_o)));
  // R4
  level_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o != $past(level_o)) |-> (rise_o || fall_o));
  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < lim_i);
  // R6
  lim_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_i != '0);

endmodule

// File: rtl/din_conditioner.sv
module din_conditioner
  import din_cond_pkg::*;
#(
  parameter int unsigned TICKS_PER_US = 80
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic       mode_i,
  input  logic [3:0] sel_i,
  input  logic       invert_i,
  input  logic       init_i,
  output logic       level_o,
  output logic       rise_o,
  output logic       fall_o
);

  localparam int unsigned CNT_W = $clog2(MAX_US * TICKS_PER_US + 1);

  logic             s_raw, s_vld, s_pol;
  logic [CNT_W-1:0] lim;
  filt_mode_e       mode;

  assign mode = filt_mode_e'(mode_i);

  din_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .s_o    (s_raw),
    .vld_o  (s_vld)
  );

  assign s_pol = s_raw ^ invert_i;

  din_limit_sel #(
    .TICKS_PER_US (TICKS_PER_US),
    .CNT_W        (CNT_W)
  ) u_lim (
    .mode_i (mode),
    .sel_i  (sel_i),
    .lim_o  (lim)
  );

  din_filter #(
    .CNT_W (CNT_W)
  ) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (init_i),
    .vld_i   (s_vld),
    .s_i     (s_pol),
    .lim_i   (lim),
    .level_o (level_o),
    .rise_o  (rise_o),
    .fall_o  (fall_o)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!rise_o && !fall_o && level_o == init_i));

endmodule

// File: tb/tb_din_conditioner.sv
module tb_din_conditioner;

  localparam int TPU = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0, mode = 1'b0, inv = 1'b0, init = 1'b0;
  logic [3:0] sel = 4'd0;
  logic       level, rise, fall;

  always #2 clk = ~clk;

  din_conditioner #(.TICKS_PER_US(TPU)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .mode_i(mode), .sel_i(sel),
    .invert_i(inv), .init_i(init), .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic  dir;
    int    at;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0, bad = 0;
  logic exp_lvl = 1'b0;

  function automatic int n_deb(int idx);
    int us;
    case (idx)
      0: us = 0;     1: us = 10;   2: us = 50;   3: us = 100;
      4: us = 200;   5: us = 400;  6: us = 600;  7: us = 1000;
      default: us = 5000;
    endcase
    return (us * TPU < 1) ? 1 : us * TPU;
  endfunction

  function automatic int n_pul(int idx);
    int r, t;
    case (idx)
      0: r = 10;    1: r = 100;   2: r = 200;   3: r = 500;
      4: r = 1000;  5: r = 2000;  6: r = 4000;
      default: r = 8000;
    endcase
    t = (500 * TPU) / r;
    return (t < 1) ? 1 : t;
  endfunction

  function automatic int cur_n();
    return mode ? n_pul(int'(sel)) : n_deb(int'(sel));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected change per strobe
  always @(negedge clk) begin
    if (rst_n && (rise || fall)) begin
      if (exp_q.size() == 0) begin
        chk(0, "R7", "unexpected strobe rise", int'(rise), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rise == e.dir && fall == !e.dir, e.req, "strobe rise", int'(rise), int'(e.dir));
        chk(cyc == e.at, e.req, "strobe cycle", cyc, e.at);
        chk(level == e.dir, e.req, "level at strobe", int'(level), int'(e.dir));
      end
    end
  end

  // driver: call at a negedge
  task automatic step(logic v, string req);
    exp_t e;
    pin = v;
    if ((v ^ inv) != exp_lvl) begin
      e.dir = v ^ inv;
      e.at  = cyc + 2 + cur_n();
      e.req = req;
      exp_q.push_back(e);
      exp_lvl = v ^ inv;
    end
    repeat (cur_n() + 8) @(negedge clk);
    chk(exp_q.size() == 0, req, "pending changes", exp_q.size(), 0);
  endtask

  task automatic glitch(logic v, int len, string req);
    pin = v;
    repeat (len) @(negedge clk);
    pin = ~v;
    repeat (cur_n() + 8) @(negedge clk);
    chk(level == exp_lvl, req, "level after short pulse", int'(level), int'(exp_lvl));
  endtask

  task automatic do_reset(logic i, logic iv, logic m, logic [3:0] s, logic p);
    exp_t e;
    rst_n = 1'b0;
    init = i; inv = iv; mode = m; sel = s; pin = p;
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R1", "leftover expectations", exp_q.size(), 0);
    exp_q.delete();
    chk(level == i, "R1", "level in reset", int'(level), int'(i));
    chk(!rise && !fall, "R1", "strobes in reset", int'(rise | fall), 0);
    exp_lvl = i;
    rst_n = 1'b1;
    if ((p ^ iv) != i) begin
      e.dir = p ^ iv;
      e.at  = cyc + 2 + cur_n();
      e.req = "R8";
      exp_q.push_back(e);
      exp_lvl = p ^ iv;
    end
    repeat (cur_n() + 8) @(negedge clk);
    chk(level == exp_lvl, "R8", "level after reset", int'(level), int'(exp_lvl));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(1'b0, 1'b0, 1'b0, 4'd0, 1'b0);
    // R3: zero stable time, 3-cycle latency
    step(1'b1, "R3");
    step(1'b0, "R3");
    // R4 / R5: index 1 -> 40 ticks
    sel = 4'd1;
    glitch(1'b1, n_deb(1) - 1, "R4");
    step(1'b1, "R5");
    step(1'b0, "R5");
    sel = 4'd2;
    step(1'b1, "R5");
    glitch(1'b0, n_deb(2) - 1, "R4");
    step(1'b0, "R5");
    // R5 longest entry and out-of-range clamp
    sel = 4'd8;
    step(1'b1, "R5");
    sel = 4'd13;
    step(1'b0, "R5");
    // R6 pulse mode
    mode = 1'b1;
    sel = 4'd0;
    glitch(1'b1, n_pul(0) - 1, "R4");
    step(1'b1, "R6");
    sel = 4'd3;
    glitch(1'b0, n_pul(3) - 1, "R4");
    step(1'b0, "R6");
    sel = 4'd6;
    step(1'b1, "R6");
    sel = 4'd10;
    step(1'b0, "R6");
    sel = 4'd1;
    step(1'b1, "R6");
    step(1'b0, "R6");
    // R2: inverted polarity, pin agrees with initial High
    do_reset(1'b1, 1'b1, 1'b0, 4'd1, 1'b0);
    chk(level == 1'b1, "R2", "inverted idle level", int'(level), 1);
    step(1'b1, "R2");
    chk(level == 1'b0, "R2", "inverted high pin", int'(level), 0);
    step(1'b0, "R2");
    // R8: pin disagrees with initial level
    do_reset(1'b1, 1'b0, 1'b0, 4'd0, 1'b0);
    do_reset(1'b0, 1'b0, 1'b1, 4'd2, 1'b1);
    chk(exp_q.size() == 0, "R7", "unmatched expectations", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule